// File: doc/BRIEF.md
# Banked External Interrupt Trigger Router

This block collects peripheral interrupt lines in groups of 32 and turns them into a small set of core trigger outputs. Each line has four pieces of per-line state:

- a status bit that records a pending interrupt;
- a sense bit that picks edge or level detection;
- an enable bit that gates the line;
- a small vector field that picks the core trigger the line drives.

All four are reached through a simple synchronous register bus.

Software uses the block in three steps. It programs sense, enable and vector for each line it owns, then watches its trigger output. It services a pending line by writing ones to the status word. For an edge line, writing a one flips the bit, so the same write either clears a pending bit or raises it again as a software retrigger. For a level line, writing a one re-asserts the line for a single cycle.

Top module: `xirq_router`

## Requirements
- R1: Line n belongs to bank n/32 at bit n%32. With b the bank index, the status word of bank b is at address 8*b, the sense word at 0x40+8*b and the enable word at 0x80+8*b. The NUM_BANKS parameter ranges from 1 to 4.
- R2: After reset, every status, sense, enable and vector register reads 0, and every bit of trig_o is 0.
- R3: For an edge line (sense bit 0), a rising edge of the synchronised input sets its status bit. The bit then stays set after the input falls.
- R4: For an edge line, writing a 1 to its status bit inverts that bit. A 0->1 flip raises the interrupt, and a 1->0 flip clears it. Status bits written with 0 do not change.
- R5: If an edge line sees a synchronised rising edge in the same cycle that software writes a 1 to its status bit, the bit ends up set.
- R6: For a level line (sense bit 1), the status bit follows the synchronised input. Writing a 1 to that status bit forces it to 1 for one cycle, after which it follows the input again.
- R7: An enable bit of 1 lets a pending line reach its trigger, and an enable bit of 0 blocks it. The enable bit never changes the status bit.
- R8: The vector field of line o in bank b sits at address 0x1000*(b+1)+4*o and reads back zero-extended. A value v from 1 to NUM_TRIG steers the line to trig_o[v-1]. A value of 0, or any value above NUM_TRIG, connects the line to no trigger.
- R9: Each trig_o[t] is the registered OR of all lines that are pending, enabled and steered to trigger t. It reflects register state one clock edge after that state changes. A change on irq_i sets the status bit on the third rising clock edge and reaches trig_o on the fourth.
- R10: Misaligned addresses, banks at or above NUM_BANKS, and sense/enable offset 0xC0 all read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_BANKS*32 | Asynchronous peripheral interrupt lines |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, together with bus_en_i |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| trig_o | output | NUM_TRIG | Core trigger outputs |

## Verification
The bench builds the router with three banks and five triggers.

Three banks give 96 lines, a count that is not a power of two. This leaves the fourth status word and the fourth vector group unmapped, so the rejection of absent banks can be tested.

Five triggers make the vector field three bits wide. The codes 6 and 7 are therefore valid encodings that must drive nothing.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int BUS_AW         = 16;
  localparam int BUS_DW         = 32;

  typedef enum logic [1:0] {
    KIND_STAT  = 2'd0,
    KIND_SENSE = 2'd1,
    KIND_EN    = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_bank.sv
module xirq_bank import xirq_pkg::*; (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LINES_PER_BANK-1:0] sync_i,
  input  logic                      stat_we_i,
  input  logic                      sense_we_i,
  input  logic                      en_we_i,
  input  logic [LINES_PER_BANK-1:0] wdata_i,
  output logic [LINES_PER_BANK-1:0] stat_o,
  output logic [LINES_PER_BANK-1:0] sense_o,
  output logic [LINES_PER_BANK-1:0] en_o
);
  logic [LINES_PER_BANK-1:0] prev_q, stat_q, sense_q, en_q;
  logic [LINES_PER_BANK-1:0] rise, flip, edge_nxt, lvl_nxt;

  assign rise     = sync_i & ~prev_q;
  assign flip     = stat_we_i ? wdata_i : '0;
  // hardware edge dominates a same-cycle software flip
  assign edge_nxt = rise | (stat_q ^ flip);
  assign lvl_nxt  = sync_i | flip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      stat_q  <= '0;
      sense_q <= '0;
      en_q    <= '0;
    end else begin
      prev_q <= sync_i;
      stat_q <= (sense_q & lvl_nxt) | (~sense_q & edge_nxt);
      if (sense_we_i) sense_q <= wdata_i;
      if (en_we_i)    en_q    <= wdata_i;
    end
  end

  assign stat_o  = stat_q;
  assign sense_o = sense_q;
  assign en_o    = en_q;
endmodule

// File: rtl/xirq_route.sv
module xirq_route #(
  parameter int NUM_LINES = 128,
  parameter int NUM_TRIG  = 4,
  parameter int VEC_W     = 3,
  parameter int LINE_W    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vec_we_i,
  input  logic [LINE_W-1:0]    vec_widx_i,
  input  logic [VEC_W-1:0]     vec_wdata_i,
  input  logic [LINE_W-1:0]    vec_ridx_i,
  output logic [VEC_W-1:0]     vec_rdata_o,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [NUM_TRIG-1:0]  trig_o
);
  logic [VEC_W-1:0]    vec_q [NUM_LINES];
  logic [NUM_TRIG-1:0] hit, trig_q;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                    vec_q[n] <= '0;
      else if (vec_we_i && vec_widx_i == LINE_W'(n))  vec_q[n] <= vec_wdata_i;
  end

  assign vec_rdata_o = (int'(vec_ridx_i) < NUM_LINES) ? vec_q[vec_ridx_i] : '0;

  // codes 0 and above NUM_TRIG match no trigger
  always_comb begin
    hit = '0;
    for (int t = 0; t < NUM_TRIG; t++)
      for (int n = 0; n < NUM_LINES; n++)
        if (pend_i[n] && vec_q[n] == VEC_W'(t + 1)) hit[t] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= hit;

  assign trig_o = trig_q;
endmodule

// File: rtl/xirq_router.sv
module xirq_router import xirq_pkg::*; #(
  parameter int NUM_BANKS   = 4,
  parameter int NUM_TRIG    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_i,
  input  logic                                bus_en_i,
  input  logic                                bus_we_i,
  input  logic [BUS_AW-1:0]                   bus_addr_i,
  input  logic [BUS_DW-1:0]                   bus_wdata_i,
  output logic [BUS_DW-1:0]                   bus_rdata_o,
  output logic [NUM_TRIG-1:0]                 trig_o
);
  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int VEC_W     = $clog2(NUM_TRIG + 1);

  logic [3:0]        region;
  logic [2:0]        lo_bank;
  reg_kind_e         kind;
  logic              lo_hit, vec_hit, bus_wr;
  logic [1:0]        vbank;
  logic [4:0]        voff;
  logic [LINE_W-1:0] vidx;
  logic [VEC_W-1:0]  vec_rd;

  logic [NUM_LINES-1:0] sync_w, stat_w, sense_w, en_w, pend;

  // address decode: 0x0000 page holds bank words, pages 1..NUM_BANKS hold vectors
  assign bus_wr  = bus_en_i && bus_we_i;
  assign region  = bus_addr_i[15:12];
  assign kind    = reg_kind_e'(bus_addr_i[7:6]);
  assign lo_bank = bus_addr_i[5:3];
  assign lo_hit  = (region == 4'd0) && (bus_addr_i[11:8] == 4'd0) &&
                   (bus_addr_i[2:0] == 3'd0) && (kind != KIND_NONE) &&
                   (int'(lo_bank) < NUM_BANKS);
  assign vec_hit = (region != 4'd0) && (int'(region) <= NUM_BANKS) &&
                   (bus_addr_i[11:7] == 5'd0) && (bus_addr_i[1:0] == 2'd0);
  assign vbank   = 2'(region - 4'd1);
  assign voff    = bus_addr_i[6:2];
  assign vidx    = LINE_W'(int'(vbank) * LINES_PER_BANK + int'(voff));

  xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (sync_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = bus_wr && lo_hit && (lo_bank == 3'(b));

    xirq_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync_w[b*LINES_PER_BANK +: LINES_PER_BANK]),
      .stat_we_i  (sel && kind == KIND_STAT),
      .sense_we_i (sel && kind == KIND_SENSE),
      .en_we_i    (sel && kind == KIND_EN),
      .wdata_i    (bus_wdata_i),
      .stat_o     (stat_w[b*LINES_PER_BANK +: LINES_PER_BANK]),
      .sense_o    (sense_w[b*LINES_PER_BANK +: LINES_PER_BANK]),
      .en_o       (en_w[b*LINES_PER_BANK +: LINES_PER_BANK])
    );
  end

  assign pend = stat_w & en_w;

  xirq_route #(
    .NUM_LINES (NUM_LINES),
    .NUM_TRIG  (NUM_TRIG),
    .VEC_W     (VEC_W),
    .LINE_W    (LINE_W)
  ) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vec_we_i    (bus_wr && vec_hit),
    .vec_widx_i  (vidx),
    .vec_wdata_i (bus_wdata_i[VEC_W-1:0]),
    .vec_ridx_i  (vidx),
    .vec_rdata_o (vec_rd),
    .pend_i      (pend),
    .trig_o      (trig_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (lo_hit) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (lo_bank == 3'(b)) begin
          case (kind)
            KIND_STAT:  bus_rdata_o = stat_w[b*LINES_PER_BANK +: LINES_PER_BANK];
            KIND_SENSE: bus_rdata_o = sense_w[b*LINES_PER_BANK +: LINES_PER_BANK];
            KIND_EN:    bus_rdata_o = en_w[b*LINES_PER_BANK +: LINES_PER_BANK];
            default:    bus_rdata_o = '0;
          endcase
        end
      end
    end else if (vec_hit) begin
      bus_rdata_o = BUS_DW'(vec_rd);
    end
  end
endmodule

// File: rtl/xirq_router_chk.sv
module xirq_router_chk #(
  parameter int NUM_LINES = 128,
  parameter int NUM_TRIG  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_en_i,
  input logic                 bus_we_i,
  input logic [15:0]          bus_addr_i,
  input logic [31:0]          bus_wdata_i,
  input logic [NUM_TRIG-1:0]  trig_o,
  input logic [NUM_LINES-1:0] pend,
  input logic [31:0]          en0_w,
  input logic                 sync0,
  input logic                 stat0,
  input logic                 sense0
);
  // R2: trigger outputs are quiet on the first edge out of reset
  p_reset_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> trig_o == '0);

  // R5: a synchronised rise on an edge line leaves its status set
  p_edge_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense0 && sync0 && !$past(sync0)) |=> stat0);

  // R6: a level line with its input high is pending
  p_level_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense0 && sync0) |=> stat0);

  // R7: bank 0 enable word takes the written value
  p_en_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == 16'h0080) |=> en0_w == $past(bus_wdata_i));

  // R9: no pending enabled line means no trigger on the next cycle
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |=> trig_o == '0);
endmodule

bind xirq_router xirq_router_chk #(
  .NUM_LINES (NUM_BANKS * 32),
  .NUM_TRIG  (NUM_TRIG)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .trig_o      (trig_o),
  .pend        (pend),
  .en0_w       (en_w[31:0]),
  .sync0       (sync_w[0]),
  .stat0       (stat_w[0]),
  .sense0      (sense_w[0])
);

// File: tb/xirq_router_bench.sv
`timescale 1ns/1ps
module xirq_router_bench;
  localparam int NB = 3;
  localparam int NT = 5;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq = '0;
  logic          en = 1'b0, we = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NT-1:0] trig;

  int n_chk = 0;
  int n_fail = 0;

  logic [NL-1:0] m_stat, m_sense, m_en;
  logic [2:0]    m_vec [NL];

  always #4 clk = ~clk;

  xirq_router #(.NUM_BANKS(NB), .NUM_TRIG(NT)) u_xirq_router (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_i       (irq),
    .bus_en_i    (en),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .trig_o      (trig)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); en = 1'b0; we = 1'b0;
  endtask

  task automatic rd_now(input string req, input logic [15:0] a, input logic [31:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk); rd_now(req, a, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] vaddr(input int line);
    return 16'(4096 * (line / 32 + 1) + 4 * (line % 32));
  endfunction

  function automatic logic [NT-1:0] exp_trig();
    logic [NT-1:0] r = '0;
    for (int n = 0; n < NL; n++)
      if (m_stat[n] && m_en[n] && m_vec[n] != 3'd0 && int'(m_vec[n]) <= NT)
        r[int'(m_vec[n]) - 1] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    idle(3); rst_n = 1'b1; idle(1);

    // R2 reset state
    check("R2 trig after reset", 32'(trig), 0);
    rd("R2 status", 16'h0000, 0);
    rd("R2 sense", 16'h0048, 0);
    rd("R2 enable", 16'h0090, 0);
    rd("R2 vector", 16'h307C, 0);

    // R1/R8 line 37 -> bank 1 bit 5, steer to trigger 1
    wr(16'h0088, 32'h20);
    wr(vaddr(37), 32'd2);
    @(negedge clk); irq[37] = 1'b1;
    idle(3); check("R9 latency before 4th edge", 32'(trig), 0);
    idle(1); check("R9 latency at 4th edge", 32'(trig), 32'b00010);
    rd("R1 bank1 bit5", 16'h0008, 32'h20);
    rd("R1 bank0 untouched", 16'h0000, 0);

    // R3 hold after input falls
    @(negedge clk); irq[37] = 1'b0;
    idle(6);
    rd("R3 status held", 16'h0008, 32'h20);
    check("R3 trig held", 32'(trig), 32'b00010);

    // R4 clear by flip, R9 one clock to output
    wr(16'h0008, 32'h20);
    check("R9 trig one edge after write", 32'(trig), 32'b00010);
    rd_now("R4 flip clears", 16'h0008, 0);
    @(negedge clk); check("R9 trig cleared", 32'(trig), 0);
    wr(16'h0008, 32'h0);
    rd("R4 zero write no effect", 16'h0008, 0);
    wr(16'h0008, 32'h20);
    idle(1);
    rd("R4 retrigger status", 16'h0008, 32'h20);
    check("R4 retrigger trig", 32'(trig), 32'b00010);

    // R5 rise and flip in the same cycle
    @(negedge clk); irq[37] = 1'b1;
    @(negedge clk); @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 16'h0008; wdata = 32'h20;
    @(negedge clk); en = 1'b0; we = 1'b0;
    rd_now("R5 edge wins", 16'h0008, 32'h20);
    wr(16'h0008, 32'h20);
    rd_now("R4 flip without edge", 16'h0008, 0);

    // R6 level sense
    wr(16'h0048, 32'h20);
    idle(1);
    rd("R6 follows high", 16'h0008, 32'h20);
    check("R6 trig high", 32'(trig), 32'b00010);
    @(negedge clk); irq[37] = 1'b0;
    idle(5);
    rd("R6 follows low", 16'h0008, 0);
    check("R6 trig low", 32'(trig), 0);
    wr(16'h0008, 32'h20);
    rd_now("R6 reassert", 16'h0008, 32'h20);
    @(negedge clk); rd_now("R6 one cycle only", 16'h0008, 0);

    // R7 enable gating
    @(negedge clk); irq[37] = 1'b1;
    idle(5);
    check("R7 enabled", 32'(trig), 32'b00010);
    wr(16'h0088, 32'h0);
    idle(1);
    check("R7 blocked", 32'(trig), 0);
    rd("R7 status intact", 16'h0008, 32'h20);
    wr(16'h0088, 32'h20);
    idle(1);
    check("R7 re-enabled", 32'(trig), 32'b00010);

    // R8 vector codes
    wr(vaddr(37), 32'd0);
    idle(1); check("R8 zero disconnects", 32'(trig), 0);
    wr(vaddr(37), 32'd6);
    idle(1); check("R8 code above NUM_TRIG", 32'(trig), 0);
    rd("R8 readback", vaddr(37), 32'd6);
    wr(vaddr(37), 32'd5);
    idle(1); check("R8 top trigger", 32'(trig), 32'b10000);

    // R10 unmapped space
    rd("R10 absent bank status", 16'h0018, 0);
    wr(16'h0058, 32'hFFFF_FFFF);
    rd("R10 absent bank sense", 16'h0058, 0);
    rd("R10 kind 3", 16'h00C0, 0);
    wr(16'h4000, 32'd5);
    rd("R10 absent vector group", 16'h4000, 0);
    wr(16'h0004, 32'h1);
    rd("R10 misaligned status", 16'h0000, 0);
    wr(16'h2016, 32'd1);
    rd("R10 misaligned vector", vaddr(37), 32'd5);
    idle(1); check("R10 trig unchanged", 32'(trig), 32'b10000);

    // random phase from a fresh reset
    @(negedge clk); rst_n = 1'b0; irq = '0;
    idle(2); rst_n = 1'b1; idle(2);
    m_stat = '0; m_sense = '0; m_en = '0;
    for (int n = 0; n < NL; n++) m_vec[n] = 3'd0;

    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom_range(0, 4));
      int b = int'($urandom_range(0, NB - 1));
      logic [31:0] d = $urandom;
      logic [NL-1:0] bm = '0;
      bm[b*32 +: 32] = '1;
      case (op)
        0: begin
          logic [NL-1:0] nw = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
          m_stat = (m_sense & nw) | (~m_sense & (m_stat | (nw & ~irq)));
          @(negedge clk); irq = nw;
        end
        1: begin
          wr(16'(16'h0040 + 8 * b), d);
          m_sense[b*32 +: 32] = d;
          m_stat = (m_stat & ~m_sense) | (irq & m_sense);
        end
        2: begin
          d = d & $urandom;
          wr(16'(16'h0080 + 8 * b), d);
          m_en[b*32 +: 32] = d;
        end
        3: begin
          int ln = int'($urandom_range(0, NL - 1));
          logic [2:0] v = 3'($urandom_range(0, 7));
          wr(vaddr(ln), 32'(v));
          m_vec[ln] = v;
        end
        default: begin
          wr(16'(8 * b), d);
          m_stat = m_stat ^ ({NL{1'b0}} | ((NL'(d) << (b * 32)) & bm & ~m_sense));
        end
      endcase
      idle(6);
      check("R9 random trigger OR", 32'(trig), 32'(exp_trig()));
      if (it % 8 == 0)
        for (int k = 0; k < NB; k++)
          rd("R3 random status", 16'(8 * k), m_stat[k*32 +: 32]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule